// File: doc/BRIEF.md
# Byte-Serial AES-128 Cipher Engine

This block encrypts or decrypts one 128-bit block under a 128-bit key with the AES-128 algorithm. It is sized for a small area. The cipher state and the current round key each sit in a 128-bit register. Every byte substitution, whether on the state or in the key schedule, goes through a single 8-bit S-box, one byte per clock. The S-box computes its result from the field inverse and the affine map, so the block holds no lookup table. The remaining per-round work is the row rotation, the column mixing and the key addition. All of it is finished in one wide cycle at the end of each round.

A caller presents the key, the data block and the direction, then raises `start` for one cycle while the engine is idle. `done` pulses once when the result is ready on `dout`. The result stays on `dout` until the next accepted start.

The controller steps through these states:
- `ST_IDLE` waits and moves on when `start` is seen. An encryption goes to `ST_KSUB`; a decryption goes to `ST_XSUB`.
- `ST_XSUB` and `ST_XADV` run the forward key expansion for decryption. `ST_XSUB` takes four substitution cycles, then `ST_XADV` takes one update cycle. After the tenth update the flow goes to `ST_WHITEN`; otherwise it returns to `ST_XSUB`.
- `ST_WHITEN` adds the last round key and goes to `ST_KSUB`.
- `ST_KSUB` substitutes four key bytes and goes to `ST_SSUB`.
- `ST_SSUB` substitutes the sixteen state bytes and goes to `ST_RFIN`.
- `ST_RFIN` finishes the round. It goes to `ST_DONE` after the last round and otherwise back to `ST_KSUB`.
- `ST_DONE` lasts one cycle and then returns to `ST_IDLE`.

Top module: `aes_ser_core`

## Requirements
- R1: With `decrypt`=0, the value on `dout` at the `done` pulse is the AES-128 encryption of `din` under `key`. Byte 0 of a block is bits [127:120], and the state is filled column by column. Arithmetic is in GF(2^8) modulo x^8+x^4+x^3+x+1.
- R2: With `decrypt`=1, the value on `dout` at the `done` pulse is the AES-128 decryption of `din` under `key`, so it recovers the plaintext of R1.
- R3: An encryption raises `done` in the cycle after the 210th rising edge that follows the edge accepting `start`. That is 10 rounds of 4 key-byte cycles, 16 state-byte cycles and 1 finishing cycle.
- R4: A decryption raises `done` in the cycle after the 261st rising edge that follows the accepting edge. That is 50 cycles of forward key expansion, 1 whitening cycle and 210 round cycles.
- R5: `done` is high for exactly one cycle per operation.
- R6: While an operation is in progress, `start`, `decrypt`, `key` and `din` have no effect. They are sampled only on the edge that accepts `start` in the idle state, and the result is unchanged by any later change.
- R7: After `done`, `dout` holds the result unchanged until a new `start` is accepted.
- R8: During and after reset, `done` is 0 and `dout` is all zeros, and the engine accepts `start` on the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when idle) |
| decrypt | input | 1 | 0 = encrypt, 1 = decrypt; sampled with start |
| key | input | 128 | Cipher key, byte 0 in bits [127:120] |
| din | input | 128 | Input block, byte 0 in bits [127:120] |
| dout | output | 128 | Result block, valid from done onward |
| done | output | 1 | One-cycle pulse when dout is valid |

## Verification
The engine is tried with several kinds of input:
- The published AES-128 example vector, in both directions. This separates a correct cipher from one with the wrong byte order or the wrong row-rotation direction.
- An all-zero key and block. This exercises the S-box at zero, where the field inverse is a special case.
- An all-ones key and block. This reaches the top of the field.
- Seeded random keys and blocks. Each is encrypted and compared with a reference computed in the bench, and the result is decrypted back. This exposes faults in the column mixing and in the backward key schedule that a single vector might hide.
- Runs in which `start` is pulsed again with different key, data and direction partway through. These show whether inputs leak into a busy operation.

// File: rtl/aes_ser_pkg.sv
package aes_ser_pkg;

    localparam int BLK_BYTES  = 16;
    localparam int WORD_BYTES = 4;
    localparam int NUM_ROUNDS = 10;
    localparam int BLK_BITS   = BLK_BYTES * 8;
    localparam int WORD_BITS  = WORD_BYTES * 8;
    localparam int BIDX_W     = $clog2(BLK_BYTES);
    localparam int RND_W      = $clog2(NUM_ROUNDS + 1);
    localparam int KEXP_STEPS = NUM_ROUNDS * (WORD_BYTES + 1);

    typedef logic [7:0]           byte_t;
    typedef logic [BLK_BITS-1:0]  blk_t;
    typedef logic [WORD_BITS-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XSUB,
        ST_XADV,
        ST_WHITEN,
        ST_KSUB,
        ST_SSUB,
        ST_RFIN,
        ST_DONE
    } fsm_t;

    // multiply by x in the AES field
    function automatic byte_t xt(byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // general field product, shift-and-add
    function automatic byte_t gmul(byte_t a, byte_t b);
        byte_t p;
        byte_t m;
        p = 8'h00;
        m = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ m;
            m = xt(m);
        end
        return p;
    endfunction

    // round constant for schedule step r (r = 1 gives 01)
    function automatic byte_t rcon_of(logic [RND_W-1:0] r);
        byte_t c;
        c = 8'h01;
        for (int i = 1; i < NUM_ROUNDS; i++) begin
            if (i < int'(r)) c = xt(c);
        end
        return c;
    endfunction

endpackage

// File: rtl/aes_ser_sbox.sv
module aes_ser_sbox
    import aes_ser_pkg::*;
(
    input  byte_t a,
    input  logic  inv,
    output byte_t y
);

    function automatic byte_t fwd_affine(byte_t v);
        byte_t r;
        for (int i = 0; i < 8; i++) begin
            r[i] = v[i] ^ v[(i + 4) % 8] ^ v[(i + 5) % 8]
                 ^ v[(i + 6) % 8] ^ v[(i + 7) % 8];
        end
        return r ^ 8'h63;
    endfunction

    function automatic byte_t rev_affine(byte_t v);
        byte_t r;
        for (int i = 0; i < 8; i++) begin
            r[i] = v[(i + 2) % 8] ^ v[(i + 5) % 8] ^ v[(i + 7) % 8];
        end
        return r ^ 8'h05;
    endfunction

    // a^254 equals a^-1 for nonzero a and 0 for a = 0
    function automatic byte_t field_inv(byte_t v);
        byte_t sq;
        byte_t acc;
        sq  = v;
        acc = 8'h01;
        for (int i = 1; i < 8; i++) begin
            sq  = gmul(sq, sq);
            acc = gmul(acc, sq);
        end
        return acc;
    endfunction

    byte_t pre;
    byte_t mid;

    always_comb begin
        pre = inv ? rev_affine(a) : a;
        mid = field_inv(pre);
        y   = inv ? mid : fwd_affine(mid);
    end

endmodule

// File: rtl/aes_ser_keystep.sv
module aes_ser_keystep
    import aes_ser_pkg::*;
(
    input  blk_t  rk,
    input  word_t subw,
    input  byte_t rc,
    input  logic  back,
    output word_t srcw,
    output blk_t  nk
);

    word_t w [WORD_BYTES];
    word_t f [WORD_BYTES];
    word_t b [WORD_BYTES];
    word_t src;
    word_t t;

    genvar j;
    generate
        for (j = 0; j < WORD_BYTES; j++) begin : g_words
            assign w[j] = rk[BLK_BITS-1-WORD_BITS*j -: WORD_BITS];
            assign nk[BLK_BITS-1-WORD_BITS*j -: WORD_BITS] = back ? b[j] : f[j];
        end
    endgenerate

    // forward steps use the last word; backward steps rebuild it first
    assign src  = back ? (w[3] ^ w[2]) : w[3];
    assign srcw = {src[WORD_BITS-9:0], src[WORD_BITS-1 -: 8]};
    assign t    = subw ^ {rc, {(WORD_BITS-8){1'b0}}};

    always_comb begin
        f[0] = w[0] ^ t;
        for (int k = 1; k < WORD_BYTES; k++) f[k] = w[k] ^ f[k-1];
        b[0] = w[0] ^ t;
        for (int k = 1; k < WORD_BYTES; k++) b[k] = w[k] ^ w[k-1];
    end

endmodule

// File: rtl/aes_ser_round.sv
module aes_ser_round
    import aes_ser_pkg::*;
(
    input  blk_t s,
    input  blk_t rk,
    input  logic dec,
    input  logic last,
    output blk_t y
);

    localparam int NCOL = BLK_BYTES / WORD_BYTES;

    blk_t sr;
    blk_t isr;
    blk_t mc;
    blk_t tdec;
    blk_t imc;

    genvar r, c;
    generate
        for (c = 0; c < NCOL; c++) begin : g_col
            for (r = 0; r < WORD_BYTES; r++) begin : g_row
                assign sr[BLK_BITS-1-8*(r+4*c) -: 8]  =
                    s[BLK_BITS-1-8*(r+4*((c+r)%NCOL)) -: 8];
                assign isr[BLK_BITS-1-8*(r+4*c) -: 8] =
                    s[BLK_BITS-1-8*(r+4*((c+NCOL-r)%NCOL)) -: 8];
            end

            // forward column mixing on the rotated state
            for (r = 0; r < WORD_BYTES; r++) begin : g_mix
                assign mc[BLK_BITS-1-8*(r+4*c) -: 8] =
                      gmul(sr[BLK_BITS-1-8*(((r+0)%4)+4*c) -: 8], 8'h02)
                    ^ gmul(sr[BLK_BITS-1-8*(((r+1)%4)+4*c) -: 8], 8'h03)
                    ^      sr[BLK_BITS-1-8*(((r+2)%4)+4*c) -: 8]
                    ^      sr[BLK_BITS-1-8*(((r+3)%4)+4*c) -: 8];
                assign imc[BLK_BITS-1-8*(r+4*c) -: 8] =
                      gmul(tdec[BLK_BITS-1-8*(((r+0)%4)+4*c) -: 8], 8'h0e)
                    ^ gmul(tdec[BLK_BITS-1-8*(((r+1)%4)+4*c) -: 8], 8'h0b)
                    ^ gmul(tdec[BLK_BITS-1-8*(((r+2)%4)+4*c) -: 8], 8'h0d)
                    ^ gmul(tdec[BLK_BITS-1-8*(((r+3)%4)+4*c) -: 8], 8'h09);
            end
        end
    endgenerate

    assign tdec = isr ^ rk;

    always_comb begin
        if (dec) y = last ? tdec : imc;
        else     y = (last ? sr : mc) ^ rk;
    end

endmodule

// File: rtl/aes_ser_core.sv
module aes_ser_core
    import aes_ser_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         decrypt,
    input  logic [127:0] key,
    input  logic [127:0] din,
    output logic [127:0] dout,
    output logic         done
);

    localparam logic [BIDX_W-1:0] LAST_KBYTE = BIDX_W'(WORD_BYTES - 1);
    localparam logic [BIDX_W-1:0] LAST_SBYTE = BIDX_W'(BLK_BYTES - 1);
    localparam logic [RND_W-1:0]  LAST_RND   = RND_W'(NUM_ROUNDS);
    localparam logic [RND_W-1:0]  FIRST_RND  = RND_W'(1);

    fsm_t              fsm_q, fsm_d;
    blk_t              state_q;
    blk_t              rkey_q;
    word_t             subw_q;
    logic [BIDX_W-1:0] bidx_q;
    logic [RND_W-1:0]  rnd_q;
    logic              dec_q;

    byte_t sb_in, sb_out;
    logic  sb_inv;
    word_t ks_src;
    blk_t  ks_next;
    blk_t  rnd_out;
    logic  ks_back;
    logic  last_rnd;
    logic  in_ssub;

    assign in_ssub  = (fsm_q == ST_SSUB);
    assign ks_back  = dec_q && (fsm_q == ST_KSUB || fsm_q == ST_RFIN);
    assign last_rnd = dec_q ? (rnd_q == FIRST_RND) : (rnd_q == LAST_RND);
    assign sb_inv   = in_ssub && dec_q;
    assign sb_in    = in_ssub
                    ? state_q[BLK_BITS-1-8*int'(bidx_q) -: 8]
                    : ks_src[WORD_BITS-1-8*int'(bidx_q[1:0]) -: 8];

    aes_ser_sbox u_sbox (
        .a   (sb_in),
        .inv (sb_inv),
        .y   (sb_out)
    );

    aes_ser_keystep u_keystep (
        .rk   (rkey_q),
        .subw (subw_q),
        .rc   (rcon_of(rnd_q)),
        .back (ks_back),
        .srcw (ks_src),
        .nk   (ks_next)
    );

    aes_ser_round u_round (
        .s    (state_q),
        .rk   (ks_next),
        .dec  (dec_q),
        .last (last_rnd),
        .y    (rnd_out)
    );

    // next-state logic
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            ST_IDLE:   if (start) fsm_d = decrypt ? ST_XSUB : ST_KSUB;
            ST_XSUB:   if (bidx_q == LAST_KBYTE) fsm_d = ST_XADV;
            ST_XADV:   fsm_d = (rnd_q == LAST_RND) ? ST_WHITEN : ST_XSUB;
            ST_WHITEN: fsm_d = ST_KSUB;
            ST_KSUB:   if (bidx_q == LAST_KBYTE) fsm_d = ST_SSUB;
            ST_SSUB:   if (bidx_q == LAST_SBYTE) fsm_d = ST_RFIN;
            ST_RFIN:   fsm_d = last_rnd ? ST_DONE : ST_KSUB;
            ST_DONE:   fsm_d = ST_IDLE;
            default:   fsm_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= ST_IDLE;
        else        fsm_q <= fsm_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
            rkey_q  <= '0;
            subw_q  <= '0;
            bidx_q  <= '0;
            rnd_q   <= '0;
            dec_q   <= 1'b0;
        end else begin
            unique case (fsm_q)
                ST_IDLE: begin
                    if (start) begin
                        dec_q   <= decrypt;
                        rkey_q  <= key;
                        state_q <= decrypt ? din : (din ^ key);
                        rnd_q   <= FIRST_RND;
                        bidx_q  <= '0;
                    end
                end
                ST_XSUB, ST_KSUB: begin
                    subw_q[WORD_BITS-1-8*int'(bidx_q[1:0]) -: 8] <= sb_out;
                    bidx_q <= (bidx_q == LAST_KBYTE) ? '0 : bidx_q + BIDX_W'(1);
                end
                ST_XADV: begin
                    rkey_q <= ks_next;
                    if (rnd_q != LAST_RND) rnd_q <= rnd_q + RND_W'(1);
                end
                ST_WHITEN: begin
                    state_q <= state_q ^ rkey_q;
                end
                ST_SSUB: begin
                    state_q[BLK_BITS-1-8*int'(bidx_q) -: 8] <= sb_out;
                    bidx_q <= (bidx_q == LAST_SBYTE) ? '0 : bidx_q + BIDX_W'(1);
                end
                ST_RFIN: begin
                    state_q <= rnd_out;
                    rkey_q  <= ks_next;
                    rnd_q   <= dec_q ? rnd_q - RND_W'(1) : rnd_q + RND_W'(1);
                end
                ST_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        dout = state_q;
        done = (fsm_q == ST_DONE);
    end

endmodule

// File: rtl/aes_ser_checker.sv
module aes_ser_checker
    import aes_ser_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic [127:0]     dout,
    input fsm_t             fsm,
    input logic [BIDX_W-1:0] bidx,
    input logic [RND_W-1:0] rnd,
    input logic             dec_q
);

    logic busy;
    assign busy = (fsm != ST_IDLE) && (fsm != ST_DONE);

    // R5: single-cycle completion pulse
    a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: completion only follows a finishing round
    a_r5_done_after_round: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(fsm) == ST_RFIN));

    // R6: a running operation never drops back to idle early
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (fsm != ST_IDLE));

    // R6: direction is frozen once accepted
    a_r6_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm != ST_IDLE) |=> $stable(dec_q));

    // R7: result held while idle without a new start
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm == ST_IDLE && !start) |=> $stable(dout));

    // R7: result held across the completion cycle
    a_r7_hold_done: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm == ST_DONE) |=> $stable(dout));

    // R3: key substitution covers exactly four bytes
    a_r3_key_byte_range: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm == ST_KSUB || fsm == ST_XSUB) |-> (bidx < BIDX_W'(WORD_BYTES)));

    // R4: round counter stays in 1..NUM_ROUNDS while working
    a_r4_round_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rnd >= RND_W'(1) && rnd <= RND_W'(NUM_ROUNDS)));

endmodule

bind aes_ser_core aes_ser_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .done  (done),
    .dout  (dout),
    .fsm   (fsm_q),
    .bidx  (bidx_q),
    .rnd   (rnd_q),
    .dec_q (dec_q)
);

// File: tb/aes_ser_core_bench.sv
module aes_ser_core_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         decrypt = 1'b0;
    logic [127:0] key = '0;
    logic [127:0] din = '0;
    logic [127:0] dout;
    logic         done;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] fsb [256];
    logic [7:0] isb [256];

    always #5 clk = ~clk;

    aes_ser_core u_aes_ser_core (
        .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
        .key(key), .din(din), .dout(dout), .done(done)
    );

    // ---------------- reference model ----------------
    function automatic logic [7:0] bmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        logic [7:0] y = b;
        while (y != 0) begin
            if (y[0]) p ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
            y = y >> 1;
        end
        return p;
    endfunction

    function automatic logic [7:0] rl(logic [7:0] v, int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    task automatic build_tables();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] iv = 8'h00;
            for (int y = 1; y < 256; y++)
                if (bmul(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
            fsb[x] = iv ^ rl(iv, 1) ^ rl(iv, 2) ^ rl(iv, 3) ^ rl(iv, 4) ^ 8'h63;
        end
        for (int x = 0; x < 256; x++) isb[fsb[x]] = 8'(x);
    endtask

    function automatic void expand(input logic [127:0] k, output logic [7:0] w [176]);
        logic [7:0] rc = 8'h01;
        for (int i = 0; i < 16; i++) w[i] = k[127-8*i -: 8];
        for (int i = 16; i < 176; i += 4) begin
            logic [7:0] t0 = w[i-4], t1 = w[i-3], t2 = w[i-2], t3 = w[i-1];
            if (i % 16 == 0) begin
                logic [7:0] s0 = fsb[t1] ^ rc;
                t1 = fsb[t2]; t2 = fsb[t3]; t3 = fsb[t0]; t0 = s0;
                rc = bmul(rc, 8'h02);
            end
            w[i] = w[i-16] ^ t0; w[i+1] = w[i-15] ^ t1;
            w[i+2] = w[i-14] ^ t2; w[i+3] = w[i-13] ^ t3;
        end
    endfunction

    function automatic logic [127:0] ref_enc(logic [127:0] k, logic [127:0] p);
        logic [7:0] w [176];
        logic [7:0] st [16];
        logic [7:0] tp [16];
        logic [127:0] res;
        expand(k, w);
        for (int i = 0; i < 16; i++) st[i] = p[127-8*i -: 8] ^ w[i];
        for (int rd = 1; rd <= 10; rd++) begin
            for (int i = 0; i < 16; i++) st[i] = fsb[st[i]];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++) tp[r+4*c] = st[r+4*((c+r)%4)];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++)
                    st[r+4*c] = (rd == 10) ? tp[r+4*c] :
                        bmul(tp[r+4*c], 2) ^ bmul(tp[(r+1)%4+4*c], 3)
                        ^ tp[(r+2)%4+4*c] ^ tp[(r+3)%4+4*c];
            for (int i = 0; i < 16; i++) st[i] ^= w[16*rd+i];
        end
        for (int i = 0; i < 16; i++) res[127-8*i -: 8] = st[i];
        return res;
    endfunction

    function automatic logic [127:0] ref_dec(logic [127:0] k, logic [127:0] q);
        logic [7:0] w [176];
        logic [7:0] st [16];
        logic [7:0] tp [16];
        logic [127:0] res;
        expand(k, w);
        for (int i = 0; i < 16; i++) st[i] = q[127-8*i -: 8] ^ w[160+i];
        for (int rd = 9; rd >= 0; rd--) begin
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++) tp[r+4*((c+r)%4)] = st[r+4*c];
            for (int i = 0; i < 16; i++) tp[i] = isb[tp[i]] ^ w[16*rd+i];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++)
                    st[r+4*c] = (rd == 0) ? tp[r+4*c] :
                        bmul(tp[r+4*c], 8'h0e) ^ bmul(tp[(r+1)%4+4*c], 8'h0b)
                        ^ bmul(tp[(r+2)%4+4*c], 8'h0d) ^ bmul(tp[(r+3)%4+4*c], 8'h09);
        end
        for (int i = 0; i < 16; i++) res[127-8*i -: 8] = st[i];
        return res;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic run_op(input logic dm, input logic [127:0] k, input logic [127:0] d,
                          input bit disturb, output logic [127:0] res, output int lat);
        @(negedge clk);
        start = 1'b1; decrypt = dm; key = k; din = d;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat++;
            if (disturb && lat == 40) begin
                start = 1'b1; decrypt = ~dm; key = ~k; din = ~d;
            end
            if (disturb && lat == 41) start = 1'b0;
        end
        res = dout;
        key = rnd128(); din = rnd128();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [127:0] res, res2, k, p, ct;
        int lat;
        void'($urandom(32'h1a2b3c4d));
        build_tables();

        repeat (3) @(negedge clk);
        chk("R8 done in reset", {127'b0, done}, 128'b0);
        chk("R8 dout in reset", dout, 128'b0);
        rst_n = 1'b1;

        k  = 128'h000102030405060708090a0b0c0d0e0f;
        p  = 128'h00112233445566778899aabbccddeeff;
        ct = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
        chk("R1 reference model", ref_enc(k, p), ct);

        // R1 / R3 / R5 / R7 on the example vector
        run_op(1'b0, k, p, 1'b0, res, lat);
        chk("R1 example encrypt", res, ct);
        chk("R3 encrypt latency", 128'(lat), 128'd210);
        @(negedge clk);
        chk("R5 done drops", {127'b0, done}, 128'b0);
        repeat (5) @(negedge clk);
        chk("R7 dout held", dout, ct);

        // R2 / R4 on the example vector
        run_op(1'b1, k, ct, 1'b0, res, lat);
        chk("R2 example decrypt", res, p);
        chk("R4 decrypt latency", 128'(lat), 128'd261);
        @(negedge clk);
        chk("R5 done drops after decrypt", {127'b0, done}, 128'b0);

        // corner: all-zero and all-ones inputs
        run_op(1'b0, '0, '0, 1'b0, res, lat);
        chk("R1 zero key and block", res, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
        run_op(1'b0, '1, '1, 1'b0, res, lat);
        chk("R1 all-ones encrypt", res, ref_enc('1, '1));
        run_op(1'b1, '1, res, 1'b0, res2, lat);
        chk("R2 all-ones decrypt", res2, '1);

        // R6: inputs and start changed while busy
        k = rnd128(); p = rnd128();
        run_op(1'b0, k, p, 1'b1, res, lat);
        chk("R6 encrypt undisturbed", res, ref_enc(k, p));
        chk("R6 encrypt latency undisturbed", 128'(lat), 128'd210);
        run_op(1'b1, k, res, 1'b1, res2, lat);
        chk("R6 decrypt undisturbed", res2, p);

        // random round trips
        for (int n = 0; n < 16; n++) begin
            k = rnd128(); p = rnd128();
            run_op(1'b0, k, p, 1'b0, res, lat);
            chk("R1 random encrypt", res, ref_enc(k, p));
            run_op(1'b1, k, res, 1'b0, res2, lat);
            chk("R2 random decrypt", res2, p);
            if (n == 0) chk("R2 reference inverse", ref_dec(k, res), p);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule